// File: doc/BRIEF.md
# Pipeline Sequencer with Delayed Branch and Load Register Locking

This block is the control path of a four-stage load/store pipeline: fetch (I), register read (E1), ALU operation with register write (E2) and memory access (D). It owns the program counter and the stage-valid flags. It decides each cycle whether the instruction in E1 may advance. Register file, ALU and memories sit outside the block. The block drives their write enables and register addresses, and it receives the branch condition computed by the datapath.

Control transfers use a single delay slot. The instruction fetched right after a branch or jump always runs, and no stage is ever cleared. The target is PC-relative and is computed while the branch is in E2. It drives the fetch address in that same cycle.

Loads complete late, one cycle after their E2 step. A load therefore locks its destination register when it leaves E1, and the lock is released when D writes the loaded value back. Instructions that do not touch a locked register keep issuing. An instruction that reads or writes a locked register waits in E1 until the lock is released. Fetch and data access are assumed to use separate ports, so the two can occur in the same cycle.

Top module: `dslot_pipe_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after the synchronised release, `pc_o` is 0 and `stall_o`, `e1_valid_o`, `e2_valid_o`, `d_valid_o`, `alu_we_o` and `ld_we_o` are all 0.
- R2: With no stall and no redirect, `pc_o` rises by one every cycle. A word fetched in cycle n sits in E1 in cycle n+1 and in E2 in cycle n+2, and `e2_pc_o` then equals its fetch address.
- R3: Instruction words are 16 bits wide, with the opcode in [15:12]. The opcodes are: 0 no-op; 1 ALU op (writes [11:8], reads [7:4] and [3:0]); 2 load (writes [11:8], reads [7:4]); 3 store (reads [7:4] and [3:0]); 4 conditional branch (reads [11:8], signed offset [7:0]); 5 jump (signed offset [7:0]). Every other opcode behaves as a no-op and uses no register.
- R4: When a jump, or a branch with `cond_i`=1, is in E2, `pc_o` in that same cycle equals the branch's own address plus its sign-extended offset. Fetch then continues sequentially from the target.
- R5: The word that follows a branch or jump in program order always reaches E2. When the branch is taken, the word after that delay slot is never fetched into the pipe.
- R6: A conditional branch with `cond_i`=0 in E2 leaves the fetch sequence unchanged.
- R7: A load locks its destination register when it moves from E1 to E2. It writes back in D one cycle after E2, with `ld_we_o`=1 and `ld_waddr_o` equal to the destination, and the lock is released at the end of that cycle.
- R8: An instruction in E1 that reads a locked register stalls. A user placed directly after a load stalls 2 cycles, a user one instruction further away stalls 1 cycle, and a user two instructions further away does not stall.
- R9: An instruction in E1 that touches no locked register never stalls, even while a load is in flight.
- R10: An instruction whose destination register is locked also stalls until the lock is released.
- R11: In a stall cycle, the PC and E1 hold their contents, E2 receives a bubble (`e2_valid_o`=0 next cycle), and the instructions in E2 and D keep moving.
- R12: If a taken branch is in E2 while its delay slot stalls in E1, the target is kept. The target is fetched in the first cycle after the stall ends, and the delay slot still reaches E2 before the target.
- R13: Only loads and stores enter D (`d_valid_o`). An ALU op writes back from E2 with `alu_we_o`=1 and `alu_waddr_o` equal to its destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pc_o | output | PC_W | Fetch address for the instruction port |
| instr_i | input | 16 | Instruction word read at `pc_o` in the same cycle |
| cond_i | input | 1 | Branch condition from the datapath for the branch in E2 |
| stall_o | output | 1 | E1 instruction waits on a locked register |
| e1_valid_o | output | 1 | E1 holds an instruction |
| e2_valid_o | output | 1 | E2 holds an instruction |
| d_valid_o | output | 1 | D holds a load or store |
| e2_pc_o | output | PC_W | Address of the instruction in E2 |
| alu_we_o | output | 1 | Register write from an ALU op in E2 |
| alu_waddr_o | output | 4 | Destination of that write |
| ld_we_o | output | 1 | Register write from a load in D |
| ld_waddr_o | output | 4 | Destination of that write |

## Verification
The delicate cycle is the one where a taken jump sits in E2 while its delay slot stalls in E1 on a register still locked by a load just before the jump. In that cycle the PC must take the target even though it is being held. A program of a load, then a jump, then a delay slot that reads the loaded register forces this overlap. The bench then checks the stall, the target on `pc_o` during and after the stall, the bubble in E2, and that the delay slot retires in E2 exactly one cycle before the target.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  localparam int INSTR_W = 16;
  localparam int RADDR_W = 4;
  localparam int OFF_W   = 8;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_ALU   = 4'h1,
    OP_LOAD  = 4'h2,
    OP_STORE = 4'h3,
    OP_BR    = 4'h4,
    OP_JMP   = 4'h5
  } op_e;

  typedef struct packed {
    logic               is_alu;
    logic               is_load;
    logic               is_store;
    logic               is_br;
    logic               is_jmp;
    logic               rd_wr;
    logic               rd_rd;
    logic               rs1_rd;
    logic               rs2_rd;
    logic [RADDR_W-1:0] rd;
    logic [RADDR_W-1:0] rs1;
    logic [RADDR_W-1:0] rs2;
    logic [OFF_W-1:0]   off;
  } dec_t;

endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/dsp_decode.sv
module dsp_decode
  import dsp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  always_comb begin
    dec_o          = '0;
    dec_o.rd       = instr_i[11:8];
    dec_o.rs1      = instr_i[7:4];
    dec_o.rs2      = instr_i[3:0];
    dec_o.off      = instr_i[7:0];
    case (instr_i[15:12])
      OP_ALU: begin
        dec_o.is_alu = 1'b1;
        dec_o.rd_wr  = 1'b1;
        dec_o.rs1_rd = 1'b1;
        dec_o.rs2_rd = 1'b1;
      end
      OP_LOAD: begin
        dec_o.is_load = 1'b1;
        dec_o.rd_wr   = 1'b1;
        dec_o.rs1_rd  = 1'b1;
      end
      OP_STORE: begin
        dec_o.is_store = 1'b1;
        dec_o.rs1_rd   = 1'b1;
        dec_o.rs2_rd   = 1'b1;
      end
      OP_BR: begin
        dec_o.is_br = 1'b1;
        dec_o.rd_rd = 1'b1;
      end
      OP_JMP: begin
        dec_o.is_jmp = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dsp_lock_table.sv
module dsp_lock_table #(
  parameter int NREG = 16,
  parameter int NQ   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_en_i,
  input  logic [AW-1:0]          set_idx_i,
  input  logic                   clr_en_i,
  input  logic [AW-1:0]          clr_idx_i,
  input  logic [NQ-1:0]          q_en_i,
  input  logic [NQ-1:0][AW-1:0]  q_idx_i,
  output logic                   hit_o,
  output logic [NREG-1:0]        lock_o
);

  logic [NREG-1:0] lock_q;
  logic [NREG-1:0] lock_d;
  logic [NREG-1:0] lock_en;

  for (genvar g = 0; g < NREG; g++) begin : g_lock
    logic set_hit;
    logic clr_hit;
    assign set_hit    = set_en_i && (set_idx_i == AW'(g));
    assign clr_hit    = clr_en_i && (clr_idx_i == AW'(g));
    assign lock_en[g] = set_hit || clr_hit;
    assign lock_d[g]  = set_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lock_q[g] <= 1'b0;
      end else if (lock_en[g]) begin
        lock_q[g] <= lock_d[g];
      end
    end
  end

  always_comb begin
    hit_o = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      hit_o = hit_o | (q_en_i[q] & lock_q[q_idx_i[q]]);
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/dsp_pc_unit.sv
module dsp_pc_unit #(
  parameter int PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pc_q_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_o = redirect_i ? target_i : pc_q;
    pc_d = stall_i ? pc_o : (pc_o + PC_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_q_o = pc_q;

endmodule

// File: rtl/dslot_pipe_ctrl.sv
module dslot_pipe_ctrl
  import dsp_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [PC_W-1:0]     pc_o,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                cond_i,
  output logic                stall_o,
  output logic                e1_valid_o,
  output logic                e2_valid_o,
  output logic                d_valid_o,
  output logic [PC_W-1:0]     e2_pc_o,
  output logic                alu_we_o,
  output logic [RADDR_W-1:0]  alu_waddr_o,
  output logic                ld_we_o,
  output logic [RADDR_W-1:0]  ld_waddr_o
);

  localparam int NREG = 1 << RADDR_W;
  localparam int NQ   = 3;

  logic rst_n;

  dsp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // E1 stage
  logic               e1_v;
  logic [INSTR_W-1:0] e1_instr;
  logic [PC_W-1:0]    e1_pc;
  dec_t               e1_dec;

  // E2 stage
  logic               e2_v;
  logic [PC_W-1:0]    e2_pc;
  logic               e2_alu, e2_ld, e2_st, e2_br, e2_jmp;
  logic [RADDR_W-1:0] e2_rd;
  logic [OFF_W-1:0]   e2_off;

  // D stage
  logic               d_v;
  logic               d_ld;
  logic [RADDR_W-1:0] d_rd;

  logic               stall;
  logic               redirect;
  logic [PC_W-1:0]    target;
  logic [PC_W-1:0]    pc_q;
  logic               lock_hit;
  logic [NREG-1:0]    lock_q;
  logic               lock_set;
  logic               lock_clr;
  logic               e1_adv;
  logic               e2_to_d;

  dsp_decode u_dec (
    .instr_i (e1_instr),
    .dec_o   (e1_dec)
  );

  dsp_lock_table #(.NREG(NREG), .NQ(NQ)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .set_en_i  (lock_set),
    .set_idx_i (e1_dec.rd),
    .clr_en_i  (lock_clr),
    .clr_idx_i (d_rd),
    .q_en_i    ({e1_dec.rd_wr | e1_dec.rd_rd, e1_dec.rs2_rd, e1_dec.rs1_rd}),
    .q_idx_i   ({e1_dec.rd, e1_dec.rs2, e1_dec.rs1}),
    .hit_o     (lock_hit),
    .lock_o    (lock_q)
  );

  always_comb begin
    stall    = e1_v && lock_hit;
    e1_adv   = e1_v && !stall;
    lock_set = e1_adv && e1_dec.is_load;
    lock_clr = d_v && d_ld;
    redirect = e2_v && (e2_jmp || (e2_br && cond_i));
    target   = e2_pc + PC_W'(signed'(e2_off));
    e2_to_d  = e2_v && (e2_ld || e2_st);
  end

  dsp_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .stall_i    (stall),
    .redirect_i (redirect),
    .target_i   (target),
    .pc_o       (pc_o),
    .pc_q_o     (pc_q)
  );

  // E1 valid: set once fetch runs after reset
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      e1_v <= 1'b0;
    end else if (!stall) begin
      e1_v <= 1'b1;
    end
  end

  // E1 payload: held on stall
  always_ff @(posedge clk_i) begin
    if (!stall) begin
      e1_instr <= instr_i;
      e1_pc    <= pc_o;
    end
  end

  // E2 valid: bubble on stall
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      e2_v <= 1'b0;
    end else begin
      e2_v <= e1_adv;
    end
  end

  always_ff @(posedge clk_i) begin
    if (e1_adv) begin
      e2_pc  <= e1_pc;
      e2_alu <= e1_dec.is_alu;
      e2_ld  <= e1_dec.is_load;
      e2_st  <= e1_dec.is_store;
      e2_br  <= e1_dec.is_br;
      e2_jmp <= e1_dec.is_jmp;
      e2_rd  <= e1_dec.rd;
      e2_off <= e1_dec.off;
    end
  end

  // D stage: memory operations only
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      d_v <= 1'b0;
    end else begin
      d_v <= e2_to_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (e2_to_d) begin
      d_ld <= e2_ld;
      d_rd <= e2_rd;
    end
  end

  assign stall_o     = stall;
  assign e1_valid_o  = e1_v;
  assign e2_valid_o  = e2_v;
  assign d_valid_o   = d_v;
  assign e2_pc_o     = e2_pc;
  assign alu_we_o    = e2_v && e2_alu;
  assign alu_waddr_o = e2_rd;
  assign ld_we_o     = d_v && d_ld;
  assign ld_waddr_o  = d_rd;

endmodule

// File: rtl/dsp_pipe_checker.sv
module dsp_pipe_checker #(
  parameter int PC_W = 8,
  parameter int NREG = 16,
  parameter int AW   = 4,
  parameter int IW   = 16
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            stall_o,
  input logic            redirect,
  input logic            e1_v,
  input logic [IW-1:0]   e1_instr,
  input logic [PC_W-1:0] e1_pc,
  input logic            e1_is_load,
  input logic [AW-1:0]   e1_rd,
  input logic            e2_valid_o,
  input logic [PC_W-1:0] e2_pc_o,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] pc_q,
  input logic            ld_we_o,
  input logic [AW-1:0]   ld_waddr_o,
  input logic [NREG-1:0] lock_q
);

  p_stall_bubble_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    stall_o |=> !e2_valid_o);

  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    stall_o |=> (e1_v && $stable(e1_instr) && $stable(e1_pc)));

  p_slot_flows_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (redirect && !stall_o) |=> (e2_valid_o && (e2_pc_o == $past(e1_pc))));

  p_fetch_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!stall_o && !redirect) |=> (pc_q == ($past(pc_o) + PC_W'(1))));

  p_target_kept_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stall_o && redirect) |=> (pc_q == $past(pc_o)));

  p_wb_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld_we_o |-> lock_q[ld_waddr_o]);

  p_lock_issue_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (e1_v && !stall_o && e1_is_load) |=> lock_q[$past(e1_rd)]);

endmodule

bind dslot_pipe_ctrl dsp_pipe_checker #(
  .PC_W (PC_W),
  .NREG (1 << dsp_pkg::RADDR_W),
  .AW   (dsp_pkg::RADDR_W),
  .IW   (dsp_pkg::INSTR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .stall_o    (stall_o),
  .redirect   (redirect),
  .e1_v       (e1_v),
  .e1_instr   (e1_instr),
  .e1_pc      (e1_pc),
  .e1_is_load (e1_dec.is_load),
  .e1_rd      (e1_dec.rd),
  .e2_valid_o (e2_valid_o),
  .e2_pc_o    (e2_pc_o),
  .pc_o       (pc_o),
  .pc_q       (pc_q),
  .ld_we_o    (ld_we_o),
  .ld_waddr_o (ld_waddr_o),
  .lock_q     (lock_q)
);

// File: tb/dslot_pipe_ctrl_tb.sv
module dslot_pipe_ctrl_tb;

  localparam int PC_W  = 8;
  localparam int NCYC  = 14;
  localparam int NVEC  = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pc_o;
  logic [15:0] instr_i;
  logic        cond_i = 1'b0;
  logic        stall_o, e1_valid_o, e2_valid_o, d_valid_o;
  logic [7:0]  e2_pc_o;
  logic        alu_we_o, ld_we_o;
  logic [3:0]  alu_waddr_o, ld_waddr_o;

  logic [15:0] imem [16];

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  assign instr_i = (pc_o < 8'd16) ? imem[pc_o[3:0]] : 16'h0000;

  dslot_pipe_ctrl #(.PC_W(PC_W)) u_dut (
    .clk_i, .rst_ni, .pc_o, .instr_i, .cond_i, .stall_o,
    .e1_valid_o, .e2_valid_o, .d_valid_o, .e2_pc_o,
    .alu_we_o, .alu_waddr_o, .ld_we_o, .ld_waddr_o
  );

  // Per-cycle samples of one run
  logic [7:0] s_pc   [NCYC];
  logic       s_st   [NCYC];
  logic       s_e1v  [NCYC];
  logic       s_e2v  [NCYC];
  logic [7:0] s_e2pc [NCYC];
  logic       s_dv   [NCYC];
  logic       s_alw  [NCYC];
  logic [3:0] s_alwa [NCYC];
  logic       s_ldw  [NCYC];
  logic [3:0] s_ldwa [NCYC];

  // Vector: four program words, expected stall count, requirement number
  // R8: immediate use / distance 2 / distance 3; R9 independent; R10 dest locked; R3 unknown opcode
  localparam logic [95:0] VEC [NVEC] = '{
    {16'h2120, 16'h1314, 16'h0000, 16'h0000, 16'd2, 16'd8},   // R8 immediate use
    {16'h2120, 16'h1354, 16'h0000, 16'h0000, 16'd0, 16'd9},   // R9 independent
    {16'h2120, 16'h0000, 16'h1314, 16'h0000, 16'd1, 16'd8},   // R8 distance two
    {16'h2120, 16'h0000, 16'h0000, 16'h1314, 16'd0, 16'd8},   // R8 distance three
    {16'h2120, 16'h1123, 16'h0000, 16'h0000, 16'd2, 16'd10},  // R10 write to locked
    {16'h2120, 16'h3041, 16'h0000, 16'h0000, 16'd2, 16'd8},   // R8 store data locked
    {16'h2120, 16'h2210, 16'h0000, 16'h0000, 16'd2, 16'd8},   // R8 load address locked
    {16'h2120, 16'h4103, 16'h0000, 16'h0000, 16'd2, 16'd8},   // R8 branch reads locked
    {16'h2120, 16'hF111, 16'h0000, 16'h0000, 16'd0, 16'd3},   // R3 unknown opcode no use
    {16'h2120, 16'h1314, 16'h1314, 16'h0000, 16'd2, 16'd9}    // R9 second user after release
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) imem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    // R1: state while reset is held
    @(negedge clk_i);
    chk("R1 pc in reset", int'(pc_o), 0);
    chk("R1 valids in reset", int'({e1_valid_o, e2_valid_o, d_valid_o, stall_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
  endtask

  task automatic run_cycles();
    for (int k = 0; k < NCYC; k++) begin
      @(negedge clk_i);
      s_pc[k]   = pc_o;
      s_st[k]   = stall_o;
      s_e1v[k]  = e1_valid_o;
      s_e2v[k]  = e2_valid_o;
      s_e2pc[k] = e2_pc_o;
      s_dv[k]   = d_valid_o;
      s_alw[k]  = alu_we_o;
      s_alwa[k] = alu_waddr_o;
      s_ldw[k]  = ld_we_o;
      s_ldwa[k] = ld_waddr_o;
    end
  endtask

  function automatic int count_stalls();
    int c = 0;
    for (int k = 0; k < NCYC; k++) c += int'(s_st[k]);
    return c;
  endfunction

  function automatic int e2_seen(input logic [7:0] pc);
    int c = 0;
    for (int k = 0; k < NCYC; k++) if (s_e2v[k] && s_e2pc[k] == pc) c++;
    return c;
  endfunction

  initial begin
    #(4 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // Table walk: load-lock scenarios
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      clear_mem();
      imem[0] = VEC[v][95:80];
      imem[1] = VEC[v][79:64];
      imem[2] = VEC[v][63:48];
      imem[3] = VEC[v][47:32];
      cond_i  = 1'b0;
      tag = $sformatf("R%0d vector %0d stalls", int'(VEC[v][15:0]), v);
      do_reset();
      run_cycles();
      chk(tag, count_stalls(), int'(VEC[v][31:16]));
      // R7: the load at address 0 writes register 1 from D in cycle 3
      chk("R7 load writeback cycle", int'({s_ldw[3], s_ldwa[3]}), int'({1'b1, 4'd1}));
    end

    // R1 / R2: sequential no-ops
    clear_mem();
    cond_i = 1'b0;
    do_reset();
    run_cycles();
    chk("R1 pc after release", int'(s_pc[0]), 0);
    chk("R1 valids after release", int'({s_e1v[0], s_e2v[0], s_dv[0], s_st[0], s_alw[0], s_ldw[0]}), 0);
    chk("R2 pc step c1", int'(s_pc[1]), 1);
    chk("R2 pc step c3", int'(s_pc[3]), 3);
    chk("R2 e2 address c2", int'({s_e2v[2], s_e2pc[2]}), int'({1'b1, 8'd0}));
    chk("R2 e2 address c3", int'(s_e2pc[3]), 1);

    // R13: ALU write from E2, never in D; store enters D
    clear_mem();
    imem[0] = 16'h1354;
    imem[1] = 16'h3041;
    do_reset();
    run_cycles();
    chk("R13 alu write c2", int'({s_alw[2], s_alwa[2]}), int'({1'b1, 4'd3}));
    chk("R13 alu not in D", int'(s_dv[2] | s_dv[3]), 0);
    chk("R13 store in D c4", int'(s_dv[4]), 1);
    chk("R13 store no ld write", int'(s_ldw[4]), 0);

    // R4 / R5: jump at 0 to 5, delay slot at 1
    clear_mem();
    imem[0] = 16'h5005;
    imem[1] = 16'h1100;
    imem[2] = 16'h1200;
    imem[5] = 16'h1300;
    do_reset();
    run_cycles();
    chk("R4 target on pc c2", int'(s_pc[2]), 5);
    chk("R4 after target c3", int'(s_pc[3]), 6);
    chk("R5 delay slot retires c3", int'({s_e2v[3], s_e2pc[3]}), int'({1'b1, 8'd1}));
    chk("R5 target in E2 c4", int'(s_e2pc[4]), 5);
    chk("R5 skipped word never in E2", e2_seen(8'd2), 0);

    // R4: negative offset from a jump at 4 back to 1
    clear_mem();
    imem[4] = 16'h50FD;
    do_reset();
    run_cycles();
    chk("R4 backward target c6", int'(s_pc[6]), 1);

    // R6: conditional branch not taken
    clear_mem();
    imem[0] = 16'h4105;
    cond_i = 1'b0;
    do_reset();
    run_cycles();
    chk("R6 untaken pc c2", int'(s_pc[2]), 2);
    chk("R6 untaken e2 c4", int'(s_e2pc[4]), 2);

    // R4: conditional branch taken
    cond_i = 1'b1;
    do_reset();
    run_cycles();
    chk("R4 taken branch pc c2", int'(s_pc[2]), 5);
    chk("R5 taken branch slot c3", int'(s_e2pc[3]), 1);
    cond_i = 1'b0;

    // R12 / R11: jump in E2 while its delay slot stalls on a load lock
    clear_mem();
    imem[0] = 16'h2120;
    imem[1] = 16'h5006;
    imem[2] = 16'h1314;
    imem[3] = 16'h1500;
    imem[7] = 16'h1600;
    do_reset();
    run_cycles();
    chk("R12 stall with redirect c3", int'(s_st[3]), 1);
    chk("R12 target on pc c3", int'(s_pc[3]), 7);
    chk("R12 target kept c4", int'(s_pc[4]), 7);
    chk("R11 bubble in E2 c4", int'(s_e2v[4]), 0);
    chk("R11 D drains c3", int'(s_dv[3]), 1);
    chk("R12 slot retires c5", int'({s_e2v[5], s_e2pc[5]}), int'({1'b1, 8'd2}));
    chk("R12 target retires c6", int'(s_e2pc[6]), 7);
    chk("R12 skipped word never in E2", e2_seen(8'd3), 0);
    chk("R12 stall count", count_stalls(), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule